// File: doc/BRIEF.md
# Signed Magnitude Comparator with Arithmetic Flags

This block orders two signed operands of a parameterised width held in two's complement. On each accepted pair it runs a trial subtraction of the second operand from the first, keeps only the condition flags of that subtraction, and turns them into a signed less-than decision and a three-way ordering code. The difference itself is never driven out.

An independent second path reaches the same three-way code by walking the operand bits. The sign bits are weighed first, with the order of 0 and 1 swapped. After that the value bits are scanned from the top down, and the first unequal bit settles the result. A mismatch output goes high whenever the two paths disagree, so the block checks its own ordering logic on every transaction. All results are registered and appear one cycle after a strobe on the valid input.

Top module: `cmp_flags_top`

## Requirements
- R1: After reset, out_vld, all flags, lt, ord and mismatch are 0.
- R2: out_vld is high exactly in the cycle after in_vld was sampled high. Outputs update only on such cycles and hold their values otherwise.
- R3: flag_z is 1 exactly when the operands are equal, that is, when the N-bit difference op_a − op_b is zero.
- R4: flag_n equals bit N−1 of the N-bit difference op_a − op_b.
- R5: flag_c is the carry out of op_a + ~op_b + 1, which is 1 exactly when op_a ≥ op_b read as unsigned numbers.
- R6: flag_v is the XOR of the carry into bit N−1 and the carry out of bit N−1. It is 1 exactly when the true signed difference falls outside the N-bit signed range.
- R7: lt equals flag_n XOR flag_v and is 1 exactly when op_a < op_b as signed values.
- R8: ord is a 2-bit signed code: 2'b01 when op_a > op_b, 2'b00 when they are equal, 2'b11 when op_a < op_b. It is taken from the flag path.
- R9: In the scan path, differing sign bits decide first: a sign of 0 against 1 gives +1, and 1 against 0 gives −1. With equal signs, bits N−2 down to 0 are compared and the highest differing bit decides, with op_a's bit at 1 giving +1. No difference gives 0.
- R10: mismatch is 1 when the scan code differs from ord. It stays 0 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair valid strobe |
| op_a | input | W | First operand (minuend) |
| op_b | input | W | Second operand (subtrahend) |
| out_vld | output | 1 | Results valid, one cycle after in_vld |
| flag_z | output | 1 | Difference is zero |
| flag_n | output | 1 | Sign of the difference |
| flag_c | output | 1 | Carry out of the subtraction |
| flag_v | output | 1 | Signed overflow of the subtraction |
| lt | output | 1 | Signed less-than |
| ord | output | 2 | Three-way ordering code |
| mismatch | output | 1 | Flag path and scan path disagree |

## Verification
The bench builds the block with W = 8. At that width the extreme operands −128 and 127 sit within easy reach of random draws, and the subtractions that overflow in both directions show up often. Directed pairs add equal operands, sign-only differences, differences only in the least significant bit, and the most negative value against itself and against zero. Random pairs then cover the rest of the 65,536 combinations in proportion.

// File: rtl/cmp_flags_pkg.sv
package cmp_flags_pkg;
    localparam logic [1:0] ORD_GT = 2'b01;
    localparam logic [1:0] ORD_EQ = 2'b00;
    localparam logic [1:0] ORD_LT = 2'b11;

    typedef struct packed {
        logic       vld;
        logic       z;
        logic       n;
        logic       c;
        logic       v;
        logic       lt;
        logic [1:0] ord;
        logic       mis;
    } cmp_res_t;
endpackage

// File: rtl/cmp_sub_flags.sv
module cmp_sub_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         z,
    output logic         n,
    output logic         c,
    output logic         v
);
    localparam int LO = W - 1;

    logic [LO-1:0] low_sum;
    logic          c_into_msb;
    logic          msb_sum;
    logic          c_out;
    logic [W-1:0]  diff;

    // Split adder so the carry into the sign bit is visible.
    always_comb begin
        {c_into_msb, low_sum} = {1'b0, a[LO-1:0]} + {1'b0, ~b[LO-1:0]} + {{LO{1'b0}}, 1'b1};
        {c_out, msb_sum}      = {1'b0, a[W-1]} + {1'b0, ~b[W-1]} + {1'b0, c_into_msb};
        diff = {msb_sum, low_sum};
        z = (diff == '0);
        n = diff[W-1];
        c = c_out;
        v = c_into_msb ^ c_out;
    end
endmodule

// File: rtl/cmp_bit_scan.sv
module cmp_bit_scan #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [1:0]   ord
);
    import cmp_flags_pkg::*;

    logic [1:0] level [W-1:0];

    // Chain from LSB upward: each bit that differs overrides lower decisions.
    genvar i;
    generate
        for (i = 0; i < W - 1; i++) begin : g_mag
            if (i == 0) begin : g_first
                assign level[i] = (a[i] == b[i]) ? ORD_EQ : (a[i] ? ORD_GT : ORD_LT);
            end else begin : g_next
                assign level[i] = (a[i] == b[i]) ? level[i-1] : (a[i] ? ORD_GT : ORD_LT);
            end
        end
    endgenerate

    // Sign bit with reversed order.
    assign level[W-1] = (a[W-1] == b[W-1]) ? level[W-2] : (a[W-1] ? ORD_LT : ORD_GT);
    assign ord = level[W-1];
endmodule

// File: rtl/cmp_flags_top.sv
module cmp_flags_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_vld,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_c,
    output logic         flag_v,
    output logic         lt,
    output logic [1:0]   ord,
    output logic         mismatch
);
    import cmp_flags_pkg::*;

    logic       f_z, f_n, f_c, f_v;
    logic [1:0] scan_ord;
    cmp_res_t   res_d, res_q;

    cmp_sub_flags #(.W(W)) u_sub (
        .a(op_a), .b(op_b), .z(f_z), .n(f_n), .c(f_c), .v(f_v)
    );

    cmp_bit_scan #(.W(W)) u_scan (
        .a(op_a), .b(op_b), .ord(scan_ord)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_vld;
        if (in_vld) begin
            res_d.z   = f_z;
            res_d.n   = f_n;
            res_d.c   = f_c;
            res_d.v   = f_v;
            res_d.lt  = f_n ^ f_v;
            res_d.ord = f_z ? ORD_EQ : ((f_n ^ f_v) ? ORD_LT : ORD_GT);
            res_d.mis = (res_d.ord != scan_ord);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld  = res_q.vld;
    assign flag_z   = res_q.z;
    assign flag_n   = res_q.n;
    assign flag_c   = res_q.c;
    assign flag_v   = res_q.v;
    assign lt       = res_q.lt;
    assign ord      = res_q.ord;
    assign mismatch = res_q.mis;

    // R2
    vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(ord) && $stable(flag_z) && $stable(lt));
    // R3
    zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (flag_z == ($past(op_a) == $past(op_b))));
    // R7
    lt_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (lt == ($signed($past(op_a)) < $signed($past(op_b)))));
    // R8
    ord_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (ord != 2'b10) && ((ord == 2'b11) == lt));
    // R10
    no_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch);
endmodule

// File: tb/cmp_flags_top_tb_top.sv
`timescale 1ns/1ps
module cmp_flags_top_tb_top;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_vld = 0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         out_vld, flag_z, flag_n, flag_c, flag_v, lt, mismatch;
    logic [1:0]   ord;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmp_flags_top #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .out_vld(out_vld), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
        .flag_v(flag_v), .lt(lt), .ord(ord), .mismatch(mismatch)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_ord(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa = $signed(a);
        int sb = $signed(b);
        if (sa > sb) return 2'b01;
        if (sa < sb) return 2'b11;
        return 2'b00;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa, sb, d;
        logic [W-1:0] diff;
        op_a = a; op_b = b; in_vld = 1;
        @(posedge clk); #1;
        in_vld = 0;
        sa = $signed(a); sb = $signed(b); d = sa - sb;
        diff = a - b;
        chk("R2 out_vld", out_vld, 1);
        chk("R3 flag_z", flag_z, (a == b));
        chk("R4 flag_n", flag_n, diff[W-1]);
        chk("R5 flag_c", flag_c, (a >= b));
        chk("R6 flag_v", flag_v, (d > 127 || d < -128));
        chk("R7 lt", lt, (sa < sb));
        chk("R8 R9 ord", ord, exp_ord(a, b));
        chk("R10 mismatch", mismatch, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        void'($urandom(32'd1234));
        #20; #1;
        chk("R1 out_vld", out_vld, 0);
        chk("R1 flags", {flag_z, flag_n, flag_c, flag_v, lt}, 0);
        chk("R1 ord", ord, 0);
        chk("R1 mismatch", mismatch, 0);
        rst_n = 1;
        @(posedge clk); #1;
        // Directed corners (R6, R9 sign ordering, LSB-only difference)
        apply(8'h80, 8'h80);
        apply(8'h80, 8'h00);
        apply(8'h00, 8'h80);
        apply(8'h7F, 8'h80);
        apply(8'h80, 8'h7F);
        apply(8'h7F, 8'hFF);
        apply(8'h01, 8'h00);
        apply(8'hFE, 8'hFF);
        apply(8'h2A, 8'h2A);
        apply(8'h0F, 8'hFB);
        // R2 hold: outputs stay when in_vld is low
        held = ord;
        op_a = 8'h00; op_b = 8'h7F;
        @(posedge clk); #1;
        chk("R2 no strobe out_vld", out_vld, 0);
        chk("R2 hold ord", ord, held);
        for (int k = 0; k < 3000; k++) begin
            apply($urandom_range(255), $urandom_range(255));
            if ($urandom_range(3) == 0) begin
                @(posedge clk); #1;
                chk("R2 idle out_vld", out_vld, 0);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule